// File: doc/BRIEF.md
# Link Receive Output Latch Controller

This block sits behind the symbol decoder of a serial link receiver. In each byte slot it takes at most one decoded symbol. The symbol is tagged as data, command, sync or invalid and comes with a value. The block routes the value to one of two registered output channels, a data word and a command word, and pulses the strobe that belongs to that channel. The other channel keeps what it last held. A received sync is a legal command: it zeroes the command word and pulses the command strobe. The host therefore sees every byte boundary on which the sender had nothing to send.

Invalid symbols change neither channel. They set a violation flag, which stays up until the next good symbol arrives. Twelve parallel lanes are shared between the two channels. A mode input divides them as 8 data + 4 command, 9 + 3 or 10 + 2. Lanes beyond the selected width are driven to zero on both outputs.

Top module: `lrx_out_latch`

## Requirements
- R1: While `rst_n` is low, `data_out`, `cmd_out`, `viol`, `data_stb` and `cmd_stb` are all zero.
- R2: A data symbol (`sym_kind` = 2'b00) sampled with `sym_valid` has the following effect one clock later. `data_out` takes `sym_value` masked to the data width, and `data_stb` is high. `cmd_out` is unchanged and `cmd_stb` is low.
- R3: A command symbol (`sym_kind` = 2'b01) has the following effect one clock later. `cmd_out` takes `sym_value[3:0]` masked to the command width, and `cmd_stb` is high. `data_out` is unchanged and `data_stb` is low.
- R4: A sync symbol (`sym_kind` = 2'b10) has the following effect one clock later. `cmd_out` becomes zero and `cmd_stb` is high. `data_out` is unchanged and `data_stb` is low.
- R5: An invalid symbol (`sym_kind` = 2'b11) leaves `data_out` and `cmd_out` unchanged and pulses no strobe. `viol` is high one clock later, the same cycle in which a valid symbol would have updated the outputs.
- R6: `viol` holds its value through idle cycles and further invalid symbols. It falls one clock after a data, command or sync symbol, together with that symbol's output update.
- R7: `width_mode` 0 selects 8 data / 4 command bits, 1 selects 9/3 and 2 selects 10/2. The value 3 acts as 0. On each update, bits of `data_out` or `cmd_out` above the selected width are zero.
- R8: A cycle with `sym_valid` low changes neither output register, and both strobes are low in the following cycle.
- R9: `data_stb` and `cmd_stb` are never high together. With `sym_valid` never high on two consecutive cycles, each strobe is high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A decoded symbol is present this cycle |
| sym_kind | input | 2 | 00 data, 01 command, 10 sync, 11 invalid |
| sym_value | input | 10 | Symbol value, data in the low data-width bits, command in the low command-width bits |
| width_mode | input | 2 | Lane split: 0 = 8/4, 1 = 9/3, 2 = 10/2, 3 = 8/4 |
| data_out | output | 10 | Registered data channel |
| cmd_out | output | 4 | Registered command channel |
| data_stb | output | 1 | One-cycle pulse on a data update |
| cmd_stb | output | 1 | One-cycle pulse on a command or sync update |
| viol | output | 1 | Violation flag |

## Verification
On every cycle, the bound checker confirms the following properties:
- each symbol kind updates only its own channel, with its own strobe, one clock after it is sampled;
- sync zeroes the command word;
- an invalid symbol or an idle cycle leaves both words untouched;
- the flag holds through idle cycles, and the two strobes stay exclusive.

The directed scenarios are needed for behaviour that spans several symbols:
- the flag persisting across a run of invalid and idle slots and then dropping on the first good symbol;
- each lane split, including the reserved mode value, truncating an all-ones value;
- the values after a reset in the middle of a run.

// File: rtl/lrx_pkg.sv
package lrx_pkg;

    typedef enum logic [1:0] {
        KIND_DATA = 2'b00,
        KIND_CMD  = 2'b01,
        KIND_SYNC = 2'b10,
        KIND_BAD  = 2'b11
    } sym_kind_e;

    typedef struct packed {
        logic take_data;
        logic take_cmd;
        logic take_sync;
        logic take_bad;
    } sym_action_t;

endpackage

// File: rtl/lrx_sym_decode.sv
module lrx_sym_decode
    import lrx_pkg::*;
(
    input  logic        sym_valid,
    input  logic [1:0]  sym_kind,
    output sym_action_t action
);

    always_comb begin
        action = '0;
        if (sym_valid) begin
            unique case (sym_kind_e'(sym_kind))
                KIND_DATA: action.take_data = 1'b1;
                KIND_CMD:  action.take_cmd  = 1'b1;
                KIND_SYNC: action.take_sync = 1'b1;
                default:   action.take_bad  = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/lrx_lane_mask.sv
module lrx_lane_mask #(
    parameter int PIN_W     = 12,
    parameter int DATA_MIN  = 8,
    parameter int NUM_MODES = 3,
    parameter int MODE_W    = 2,
    localparam int DATA_MAX = DATA_MIN + NUM_MODES - 1,
    localparam int CMD_MAX  = PIN_W - DATA_MIN,
    localparam int CNT_W    = $clog2(PIN_W + 1)
) (
    input  logic [MODE_W-1:0]   width_mode,
    output logic [DATA_MAX-1:0] data_mask,
    output logic [CMD_MAX-1:0]  cmd_mask
);

    logic [MODE_W-1:0] eff_mode;
    logic [CNT_W-1:0]  data_w;
    logic [CNT_W-1:0]  cmd_w;

    // Reserved mode codes fall back to the narrowest data split.
    always_comb begin
        if (width_mode < MODE_W'(NUM_MODES)) begin
            eff_mode = width_mode;
        end else begin
            eff_mode = '0;
        end
        data_w = CNT_W'(DATA_MIN) + CNT_W'(eff_mode);
        cmd_w  = CNT_W'(PIN_W) - data_w;
    end

    for (genvar i = 0; i < DATA_MAX; i++) begin : g_data_lane
        assign data_mask[i] = (CNT_W'(i) < data_w);
    end

    for (genvar j = 0; j < CMD_MAX; j++) begin : g_cmd_lane
        assign cmd_mask[j] = (CNT_W'(j) < cmd_w);
    end

endmodule

// File: rtl/lrx_out_latch.sv
module lrx_out_latch
    import lrx_pkg::*;
#(
    parameter int PIN_W     = 12,
    parameter int DATA_MIN  = 8,
    parameter int NUM_MODES = 3,
    parameter int MODE_W    = 2,
    localparam int DATA_MAX = DATA_MIN + NUM_MODES - 1,
    localparam int CMD_MAX  = PIN_W - DATA_MIN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sym_valid,
    input  logic [1:0]          sym_kind,
    input  logic [DATA_MAX-1:0] sym_value,
    input  logic [MODE_W-1:0]   width_mode,
    output logic [DATA_MAX-1:0] data_out,
    output logic [CMD_MAX-1:0]  cmd_out,
    output logic                data_stb,
    output logic                cmd_stb,
    output logic                viol
);

    typedef struct packed {
        logic [DATA_MAX-1:0] data;
        logic [CMD_MAX-1:0]  cmd;
        logic                dstb;
        logic                cstb;
        logic                viol;
    } latch_state_t;

    sym_action_t         action;
    logic [DATA_MAX-1:0] data_mask;
    logic [CMD_MAX-1:0]  cmd_mask;
    latch_state_t        st_d;
    latch_state_t        st_q;

    lrx_sym_decode i_decode (
        .sym_valid (sym_valid),
        .sym_kind  (sym_kind),
        .action    (action)
    );

    lrx_lane_mask #(
        .PIN_W     (PIN_W),
        .DATA_MIN  (DATA_MIN),
        .NUM_MODES (NUM_MODES),
        .MODE_W    (MODE_W)
    ) i_mask (
        .width_mode (width_mode),
        .data_mask  (data_mask),
        .cmd_mask   (cmd_mask)
    );

    // Next-state: each channel holds unless its own symbol kind arrives.
    always_comb begin
        st_d      = st_q;
        st_d.dstb = 1'b0;
        st_d.cstb = 1'b0;
        if (action.take_data) begin
            st_d.data = sym_value & data_mask;
            st_d.dstb = 1'b1;
            st_d.viol = 1'b0;
        end
        if (action.take_cmd) begin
            st_d.cmd  = sym_value[CMD_MAX-1:0] & cmd_mask;
            st_d.cstb = 1'b1;
            st_d.viol = 1'b0;
        end
        if (action.take_sync) begin
            st_d.cmd  = '0;
            st_d.cstb = 1'b1;
            st_d.viol = 1'b0;
        end
        if (action.take_bad) begin
            st_d.viol = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_out = st_q.data;
    assign cmd_out  = st_q.cmd;
    assign data_stb = st_q.dstb;
    assign cmd_stb  = st_q.cstb;
    assign viol     = st_q.viol;

endmodule

// File: rtl/lrx_out_latch_chk.sv
module lrx_out_latch_chk #(
    parameter int PIN_W     = 12,
    parameter int DATA_MIN  = 8,
    parameter int NUM_MODES = 3,
    parameter int MODE_W    = 2,
    localparam int DATA_MAX = DATA_MIN + NUM_MODES - 1,
    localparam int CMD_MAX  = PIN_W - DATA_MIN
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sym_valid,
    input logic [1:0]          sym_kind,
    input logic [DATA_MAX-1:0] sym_value,
    input logic [MODE_W-1:0]   width_mode,
    input logic [DATA_MAX-1:0] data_out,
    input logic [CMD_MAX-1:0]  cmd_out,
    input logic                data_stb,
    input logic                cmd_stb,
    input logic                viol
);

    int unsigned         exp_dw;
    logic [DATA_MAX-1:0] exp_data;
    logic [CMD_MAX-1:0]  exp_cmd;

    always_comb begin
        exp_dw = DATA_MIN;
        if (int'(width_mode) < NUM_MODES) begin
            exp_dw = DATA_MIN + int'(width_mode);
        end
        exp_data = sym_value & ({DATA_MAX{1'b1}} >> (DATA_MAX - exp_dw));
        exp_cmd  = sym_value[CMD_MAX-1:0] & ({CMD_MAX{1'b1}} >> (exp_dw - DATA_MIN));
    end

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (data_out == '0 && cmd_out == '0 && !viol && !data_stb && !cmd_stb));

    // R2, R7
    a_r2_data_update: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_kind == 2'b00) |=>
        (data_stb && !cmd_stb && !viol && data_out == $past(exp_data) && $stable(cmd_out)));

    // R3, R7
    a_r3_cmd_update: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_kind == 2'b01) |=>
        (cmd_stb && !data_stb && !viol && cmd_out == $past(exp_cmd) && $stable(data_out)));

    // R4
    a_r4_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_kind == 2'b10) |=>
        (cmd_stb && !data_stb && !viol && cmd_out == '0 && $stable(data_out)));

    // R5
    a_r5_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_kind == 2'b11) |=>
        (viol && !data_stb && !cmd_stb && $stable(data_out) && $stable(cmd_out)));

    // R6, R8
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=>
        (!data_stb && !cmd_stb && $stable(viol) && $stable(data_out) && $stable(cmd_out)));

    // R9
    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_stb && cmd_stb));

endmodule

bind lrx_out_latch lrx_out_latch_chk #(
    .PIN_W     (PIN_W),
    .DATA_MIN  (DATA_MIN),
    .NUM_MODES (NUM_MODES),
    .MODE_W    (MODE_W)
) i_chk (.*);

// File: tb/test_lrx_out_latch.sv
`timescale 1ns/1ps
module test_lrx_out_latch;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid = 1'b0;
    logic [1:0] sym_kind = 2'b00;
    logic [9:0] sym_value = '0;
    logic [1:0] width_mode = 2'd0;
    logic [9:0] data_out;
    logic [3:0] cmd_out;
    logic       data_stb;
    logic       cmd_stb;
    logic       viol;

    int checks = 0;
    int fails  = 0;

    logic [9:0] m_data = '0;
    logic [3:0] m_cmd  = '0;
    logic       m_viol = 1'b0;

    always #2.5 clk = ~clk;

    lrx_out_latch i_lrx_out_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .sym_valid  (sym_valid),
        .sym_kind   (sym_kind),
        .sym_value  (sym_value),
        .width_mode (width_mode),
        .data_out   (data_out),
        .cmd_out    (cmd_out),
        .data_stb   (data_stb),
        .cmd_stb    (cmd_stb),
        .viol       (viol)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic exp_dstb, input logic exp_cstb);
        chk({tag, " data_out"}, 32'(data_out), 32'(m_data));
        chk({tag, " cmd_out"},  32'(cmd_out),  32'(m_cmd));
        chk({tag, " viol"},     32'(viol),     32'(m_viol));
        chk({tag, " data_stb"}, 32'(data_stb), 32'(exp_dstb));
        chk({tag, " cmd_stb"},  32'(cmd_stb),  32'(exp_cstb));
    endtask

    // Bench-side width rule (R7): 0 -> 8/4, 1 -> 9/3, 2 -> 10/2, 3 -> 8/4.
    function automatic int dwidth(input logic [1:0] m);
        return (m == 2'd1) ? 9 : (m == 2'd2) ? 10 : 8;
    endfunction

    // Present one symbol, check the cycle after it, then the cycle after that.
    task automatic send(input string tag, input logic [1:0] kind, input logic [9:0] val);
        logic ed;
        logic ec;
        int   dw;
        dw = dwidth(width_mode);
        ed = 1'b0;
        ec = 1'b0;
        @(negedge clk);
        sym_valid = 1'b1;
        sym_kind  = kind;
        sym_value = val;
        case (kind)
            2'b00: begin m_data = val & (10'h3FF >> (10 - dw)); ed = 1'b1; m_viol = 1'b0; end
            2'b01: begin m_cmd = val[3:0] & (4'hF >> (dw - 8)); ec = 1'b1; m_viol = 1'b0; end
            2'b10: begin m_cmd = '0; ec = 1'b1; m_viol = 1'b0; end
            default: m_viol = 1'b1;
        endcase
        @(negedge clk);
        sym_valid = 1'b0;
        sym_value = '0;
        chk_all(tag, ed, ec);
        @(negedge clk);
        chk_all({tag, " R9 one-cycle strobe"}, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        sym_valid = 1'b1;
        sym_kind  = 2'b00;
        sym_value = 10'h155;
        repeat (3) @(negedge clk);
        chk_all("R1 reset", 1'b0, 1'b0);
        sym_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 after release", 1'b0, 1'b0);
    endtask

    task automatic t_data;
        width_mode = 2'd0;
        send("R2 data a5", 2'b00, 10'h0A5);
        send("R2 data 3c", 2'b00, 10'h03C);
    endtask

    task automatic t_cmd;
        send("R3 cmd 9", 2'b01, 10'h009);
        send("R2 data keeps cmd", 2'b00, 10'h011);
        send("R3 cmd 6", 2'b01, 10'h006);
    endtask

    task automatic t_sync;
        send("R4 sync clears cmd", 2'b10, 10'h3FF);
        send("R3 cmd after sync", 2'b01, 10'h00F);
        send("R4 second sync", 2'b10, 10'h000);
    endtask

    task automatic t_invalid;
        send("R5 invalid", 2'b11, 10'h2AA);
        repeat (4) @(negedge clk);
        chk_all("R6 viol held idle", 1'b0, 1'b0);
        send("R6 invalid again", 2'b11, 10'h0FF);
        send("R6 data clears viol", 2'b00, 10'h077);
        send("R5 invalid 2", 2'b11, 10'h000);
        send("R6 sync clears viol", 2'b10, 10'h000);
        send("R5 invalid 3", 2'b11, 10'h001);
        send("R6 cmd clears viol", 2'b01, 10'h005);
    endtask

    task automatic t_modes;
        for (int m = 0; m < 4; m++) begin
            width_mode = 2'(m);
            send($sformatf("R7 data mode %0d", m), 2'b00, 10'h3FF);
            send($sformatf("R7 cmd mode %0d", m), 2'b01, 10'h3FF);
        end
        width_mode = 2'd0;
    endtask

    task automatic t_idle;
        sym_kind  = 2'b00;
        sym_value = 10'h3FF;
        repeat (5) @(negedge clk);
        chk_all("R8 idle no change", 1'b0, 1'b0);
    endtask

    task automatic t_midrun_reset;
        send("R2 data before reset", 2'b00, 10'h0C3);
        send("R5 invalid before reset", 2'b11, 10'h000);
        rst_n = 1'b0;
        m_data = '0;
        m_cmd  = '0;
        m_viol = 1'b0;
        @(negedge clk);
        chk_all("R1 mid-run reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_data();
        t_cmd();
        t_sync();
        t_invalid();
        t_modes();
        t_idle();
        t_midrun_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule